// File: doc/BRIEF.md
# Glitch-free system clock selector

This block chooses the clock that drives the core and the peripherals. The choice is between a free-running oscillator clock and the output clock of a PLL, and a single select input makes it. A change of source never produces a runt pulse. The old source is first gated off on one of its own falling edges. The fact that it has stopped is then carried into the new source's domain through a two-flop synchroniser, and only after that is the new source gated on, again on a falling edge. Between those two points no core edge is produced. A busy flag covers the whole hand-over.

A bus clock is derived from the core clock by a toggle divider, so it runs at half the core rate. The divider is held low while a hand-over is in progress and restarts from a known phase afterwards. A select to the PLL only takes effect while the PLL reports lock. A loss of lock therefore sends the selector back to the oscillator. The block also produces the effective PLL power-on output. This output stays high while the PLL is selected or still gated through, whatever the software power request says.

Top module: `clksel_top`

## Requirements
- R1: While reset (rst_n low) is asserted and directly after it, the oscillator is the active source: busy_o is 0, bus_clk_o is 0 during reset, pll_on_o equals pll_on_req_i, and the core clock period equals the oscillator period.
- R2: With the effective select (sel_pll_i AND pll_lock_i) at 1, the core clock, once busy_o has fallen, runs at the PLL period. With it at 0, the core clock runs at the oscillator period.
- R3: The two sources are never gated through at the same time, and every high pulse of core_clk_o lasts exactly one half-period of one of the sources (no runt pulses).
- R4: Once the effective select changes, busy_o returns to 0 within 4 oscillator periods plus 4 PLL periods.
- R5: busy_o rises in the same instant that the effective select differs from the gated source. It stays high until the new source is gated through, and it stays 0 when the effective select does not change.
- R6: bus_clk_o toggles on each rising core edge, so its period is twice the core period. It is held at 0 while busy_o is 1.
- R7: pll_on_o = pll_on_req_i OR effective select OR (PLL leg active or pending). While the PLL is selected, a request of 0 leaves pll_on_o at 1.
- R8: A select of the PLL while pll_lock_i is 0 causes no change. If lock is lost while the PLL is in use, the selector falls back to the oscillator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock source |
| pll_clk | input | 1 | PLL output clock source |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_pll_i | input | 1 | 1 selects the PLL, 0 selects the oscillator |
| pll_on_req_i | input | 1 | Software request to power the PLL |
| pll_lock_i | input | 1 | PLL lock indication |
| core_clk_o | output | 1 | Gated core clock |
| bus_clk_o | output | 1 | Bus clock, core clock divided by two |
| busy_o | output | 1 | High while a source hand-over is in progress |
| pll_on_o | output | 1 | Effective PLL power enable with interlock |

## Verification
Two functions can land in the same instant. One is a source change. The other is a change of the PLL power request or of lock. For example, the PLL may be selected while the request to power it is being withdrawn, or lock may be lost while the PLL is selected. The bench sweeps every combination of select, request and lock, and applies each one as a single step from whichever source is currently active. For each step it works out the expected source as select AND lock, and the expected power output as request OR that source. It then judges the step by the busy flag just after the step, the hand-over time, the measured core and bus periods, the power output, and a pulse-width monitor that runs throughout.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  localparam int unsigned NUM_SRC = 2;
  typedef enum logic {
    SRC_OSC = 1'b0,
    SRC_PLL = 1'b1
  } src_e;
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser; the whole chain is exposed so that a
// leg can report pending activity.
module clksel_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d,
  output logic              q,
  output logic [STAGES-1:0] chain_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q       = chain[STAGES-1];
  assign chain_o = chain;
endmodule

// File: rtl/clksel_leg.sv
`timescale 1ns/1ps
// One source leg: arms only when the other leg is fully idle, then
// opens its gate on a falling edge of its own clock.
module clksel_leg #(
  parameter int unsigned STAGES = 2,
  parameter bit          RST_ON = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_i,
  input  logic other_any_i,
  output logic act_o,
  output logic any_o,
  output logic clk_gated_o
);
  logic              arm;
  logic              armed;
  logic [STAGES-1:0] chain;
  logic              act_q;

  assign arm = want_i & ~other_any_i;

  clksel_sync #(.STAGES(STAGES), .RST_VAL(RST_ON)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d       (arm),
    .q       (armed),
    .chain_o (chain)
  );

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= RST_ON;
    else        act_q <= armed;
  end

  assign act_o       = act_q;
  assign any_o       = act_q | (|chain);
  assign clk_gated_o = clk & act_q;

  // R3
  grant_excl_chk: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(act_q) |-> !other_any_i);
endmodule

// File: rtl/clksel_busdiv.sv
`timescale 1ns/1ps
// Toggle divider; cleared asynchronously during reset and hand-over.
module clksel_busdiv (
  input  logic core_clk,
  input  logic clr_i,
  output logic bus_o
);
  logic q;

  always_ff @(posedge core_clk or posedge clr_i) begin
    if (clr_i) q <= 1'b0;
    else       q <= ~q;
  end

  assign bus_o = q;
endmodule

// File: rtl/clksel_top.sv
`timescale 1ns/1ps
module clksel_top #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic osc_clk,
  input  logic pll_clk,
  input  logic rst_n,
  input  logic sel_pll_i,
  input  logic pll_on_req_i,
  input  logic pll_lock_i,
  output logic core_clk_o,
  output logic bus_clk_o,
  output logic busy_o,
  output logic pll_on_o
);
  import clksel_pkg::*;

  localparam int unsigned N = NUM_SRC;

  logic         sel_eff;
  logic [N-1:0] src_clk;
  logic [N-1:0] want;
  logic [N-1:0] act;
  logic [N-1:0] any_v;
  logic [N-1:0] gated;
  logic         div_clr;

  assign sel_eff = sel_pll_i & pll_lock_i;
  assign src_clk = {pll_clk, osc_clk};
  assign want    = {sel_eff, ~sel_eff};

  for (genvar g = 0; g < N; g++) begin : g_leg
    clksel_leg #(
      .STAGES (SYNC_STAGES),
      .RST_ON (g == int'(SRC_OSC))
    ) u_leg (
      .clk         (src_clk[g]),
      .rst_n       (rst_n),
      .want_i      (want[g]),
      .other_any_i (any_v[N-1-g]),
      .act_o       (act[g]),
      .any_o       (any_v[g]),
      .clk_gated_o (gated[g])
    );
  end

  assign core_clk_o = |gated;
  assign busy_o     = sel_eff ? ~act[SRC_PLL] : ~act[SRC_OSC];
  assign div_clr    = ~rst_n | busy_o;
  assign pll_on_o   = pll_on_req_i | sel_eff | any_v[SRC_PLL];

  clksel_busdiv u_div (
    .core_clk (core_clk_o),
    .clr_i    (div_clr),
    .bus_o    (bus_clk_o)
  );

  // R3
  mutex_osc_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !(act[SRC_OSC] && act[SRC_PLL]));
  // R3
  mutex_pll_chk: assert property (@(posedge pll_clk) disable iff (!rst_n)
    !(act[SRC_OSC] && act[SRC_PLL]));
  // R3
  core_one_src_chk: assert property (@(posedge core_clk_o) disable iff (!rst_n)
    $countones(act) == 1);
  // R6
  bus_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    busy_o |-> !bus_clk_o);
endmodule

// File: tb/clksel_top_bench.sv
`timescale 1ns/1ps
module clksel_top_bench;
  logic osc_clk = 1'b0;
  logic pll_clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, req = 1'b0, lock = 1'b0;
  logic core, bus, busy, pll_on;

  int  checks = 0;
  int  errors = 0;
  int  glitches = 0;
  bit  mon_en = 1'b0;
  bit  done = 1'b0;
  bit  cur_src = 1'b0;
  real t_rise = 0.0;

  localparam int OSC_T10 = 100;  // oscillator period, 0.1 ns units
  localparam int PLL_T10 = 60;   // PLL period, 0.1 ns units

  always #5 osc_clk = ~osc_clk;
  initial begin
    #1.3;
    forever #3 pll_clk = ~pll_clk;
  end

  clksel_top u_clksel_top (
    .osc_clk(osc_clk), .pll_clk(pll_clk), .rst_n(rst_n),
    .sel_pll_i(sel), .pll_on_req_i(req), .pll_lock_i(lock),
    .core_clk_o(core), .bus_clk_o(bus), .busy_o(busy), .pll_on_o(pll_on)
  );

  // R3 pulse-width monitor
  always @(posedge core) t_rise = $realtime;
  always @(negedge core) begin
    if (mon_en) begin
      int w10;
      w10 = int'(($realtime - t_rise) * 10.0);
      if (w10 != OSC_T10 / 2 && w10 != PLL_T10 / 2) glitches++;
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic core_period(output int p10);
    real t1;
    @(posedge core); t1 = $realtime;
    @(posedge core); p10 = int'(($realtime - t1) * 10.0);
  endtask

  task automatic bus_period(output int p10);
    real t1;
    @(posedge bus); t1 = $realtime;
    @(posedge bus); p10 = int'(($realtime - t1) * 10.0);
  endtask

  task automatic do_switch(input bit s, input bit r, input bit l);
    bit  exp_src;
    bit  change;
    real t0;
    int  p10;
    int  b10;
    int  el10;
    exp_src = s & l;
    change  = (exp_src != cur_src);
    @(negedge osc_clk); #1;
    t0 = $realtime;
    sel = s; req = r; lock = l;
    #0.5;
    chk(change ? "R5 busy on change" : "R8/R5 busy stays low", int'(busy), int'(change));
    if (change) chk("R6 bus held low in hand-over", int'(bus), 0);
    while (busy && ($realtime - t0) < 200.0) #0.1;
    el10 = int'(($realtime - t0) * 10.0);
    checks++;
    if (el10 > 4 * OSC_T10 + 4 * PLL_T10) begin
      errors++;
      $display("FAIL R4 switch time actual=%0d expected<=%0d", el10, 4 * OSC_T10 + 4 * PLL_T10);
    end
    core_period(p10);
    chk("R2/R8 core period", p10, exp_src ? PLL_T10 : OSC_T10);
    bus_period(b10);
    chk("R6 bus period", b10, 2 * (exp_src ? PLL_T10 : OSC_T10));
    chk("R7 pll_on interlock", int'(pll_on), int'(r | exp_src));
    cur_src = exp_src;
  endtask

  initial begin
    int p10;
    #23;
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 bus in reset", int'(bus), 0);
    chk("R1 pll_on in reset", int'(pll_on), 0);
    #10.1;
    rst_n = 1'b1;
    mon_en = 1'b1;
    core_period(p10);
    chk("R1 osc after reset", p10, OSC_T10);
    chk("R1 busy after reset", int'(busy), 0);
    // sweep every (select, request, lock) step from both sources
    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 8; k++) begin
        do_switch(k[2], k[1], k[0]);
        do_switch(~k[2], k[1], 1'b1);
      end
    end
    // R7: power-down request while on PLL
    do_switch(1'b1, 1'b1, 1'b1);
    do_switch(1'b1, 1'b0, 1'b1);
    // R8: lock lost while on PLL
    do_switch(1'b1, 1'b0, 1'b0);
    checks++;
    if (glitches != 0) begin
      errors++;
      $display("FAIL R3 runt pulses actual=%0d expected=0", glitches);
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule